// File: doc/BRIEF.md
# Highway and Side-Road Junction Signal Controller

This block sequences the signal heads at a junction where a busy highway meets a quiet side road. Each road has one red, one yellow and one green lamp. By default the highway shows green. It gives way to the side road only when there is a demand and the highway has already had its minimum green. A demand is either a car on the side-road sensor or a pedestrian asking to cross the highway.

Every interval is counted in pulses of a one-cycle `tick` input, normally one pulse per second. Three restartable interval timers set the timing: a long one (60 ticks), a mid one (30 ticks) and a short one (10 ticks). The state machine restarts each timer in the same cycle as the transition that needs it. These restart strobes are combinational (Mealy) outputs of the state machine.

A timed state ends on the clock edge that follows the P-th tick after the state was entered. P is the timer period that governs that state.

Top module: `tlc_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next state shows highway green and side red. On that edge, all three timers restart and any pending pedestrian request is dropped.
- R2: Highway green is held for as long as neither a side-road car nor a pending pedestrian request is present, however long that lasts.
- R3: A demand ends highway green only after LONG_TICKS ticks have passed since highway green began. The highway then shows yellow while the side road stays red.
- R4: Each yellow lasts SHORT_TICKS ticks. Highway yellow is followed by side green with highway red. Side yellow is followed by highway green with side red.
- R5: Side green lasts at least MID_TICKS ticks, even when the sensor drops during that time.
- R6: While the sensor stays high after MID_TICKS, side green continues. It ends once LONG_TICKS ticks have passed since side green began.
- R7: A one-cycle pulse on `ped_req` is remembered until served and then acts as a demand. A pulse given during the highway minimum green is not lost. The request is dropped when side green starts, so it causes exactly one side-road phase.
- R8: The timers advance only on cycles where `tick` is high. A timer that has expired stays expired until it is restarted.
- R9: Exactly one lamp of each road is lit in every cycle. Bit order in the bench is {red, yellow, green} per road.
- R10: The two roads never both show a green-or-yellow lamp in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse |
| side_car | input | 1 | Side-road car sensor, high while a car waits |
| ped_req | input | 1 | Debounced pedestrian crossing request pulse |
| hwy_red | output | 1 | Highway red lamp |
| hwy_yel | output | 1 | Highway yellow lamp |
| hwy_grn | output | 1 | Highway green lamp |
| side_red | output | 1 | Side road red lamp |
| side_yel | output | 1 | Side road yellow lamp |
| side_grn | output | 1 | Side road green lamp |

## Verification
The bench builds the block with LONG_TICKS=6, MID_TICKS=3 and SHORT_TICKS=2. Most phases hold `tick` high on every cycle. With these values a full junction cycle fits in a few dozen clocks, so each dwell boundary can be checked to the exact cycle: the highway minimum, the side minimum with the sensor dropped, the side ceiling with the sensor held, and both yellows. One phase holds `tick` low for many cycles to show that the timers stand still without timebase pulses. The bench also checks that a pedestrian pulse given early in highway green is held until served.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_HWY_GO   = 2'd0,
        PH_HWY_WARN = 2'd1,
        PH_SIDE_GO  = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_t;

    typedef struct packed {
        logic red;
        logic yel;
        logic grn;
    } lamps_t;

    localparam lamps_t LAMP_RED = '{red: 1'b1, yel: 1'b0, grn: 1'b0};
    localparam lamps_t LAMP_YEL = '{red: 1'b0, yel: 1'b1, grn: 1'b0};
    localparam lamps_t LAMP_GRN = '{red: 1'b0, yel: 1'b0, grn: 1'b1};

    typedef struct packed {
        logic restart_long;
        logic restart_mid;
        logic restart_short;
        logic ped_clear;
    } ctl_t;

    function automatic lamps_t hwy_lamps(input phase_t ph);
        case (ph)
            PH_HWY_GO:   return LAMP_GRN;
            PH_HWY_WARN: return LAMP_YEL;
            default:     return LAMP_RED;
        endcase
    endfunction

    function automatic lamps_t side_lamps(input phase_t ph);
        case (ph)
            PH_SIDE_GO:   return LAMP_GRN;
            PH_SIDE_WARN: return LAMP_YEL;
            default:      return LAMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
    parameter int PERIOD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic expired
);
    localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (tick && !expired) begin
            if (cnt == LAST) begin
                expired <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8
    sticky_done_chk: assert property (@(posedge clk) disable iff (rst)
        (expired && !restart) |=> expired);

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expired);

    // R8
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart && !expired) |=> !expired);

endmodule

// File: rtl/tlc_ped_latch.sv
module tlc_ped_latch (
    input  logic clk,
    input  logic rst,
    input  logic press,
    input  logic serve,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst || serve) begin
            pending <= 1'b0;
        end else if (press) begin
            pending <= 1'b1;
        end
    end

    // R7
    ped_serve_drop_chk: assert property (@(posedge clk) disable iff (rst)
        serve |=> !pending);

    // R7
    ped_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (press && !serve) |=> pending);

endmodule

// File: rtl/tlc_fsm.sv
module tlc_fsm
    import tlc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car,
    input  logic   ped_pending,
    input  logic   long_done,
    input  logic   mid_done,
    input  logic   short_done,
    output phase_t phase,
    output ctl_t   ctl
);
    phase_t phase_nx;

    always_comb begin
        phase_nx = phase;
        ctl      = '0;
        unique case (phase)
            PH_HWY_GO: begin
                if (long_done && (car || ped_pending)) begin
                    phase_nx          = PH_HWY_WARN;
                    ctl.restart_short = 1'b1;
                end
            end
            PH_HWY_WARN: begin
                if (short_done) begin
                    phase_nx         = PH_SIDE_GO;
                    ctl.restart_long = 1'b1;
                    ctl.restart_mid  = 1'b1;
                    ctl.ped_clear    = 1'b1;
                end
            end
            PH_SIDE_GO: begin
                if (mid_done && (!car || long_done)) begin
                    phase_nx          = PH_SIDE_WARN;
                    ctl.restart_short = 1'b1;
                end
            end
            PH_SIDE_WARN: begin
                if (short_done) begin
                    phase_nx         = PH_HWY_GO;
                    ctl.restart_long = 1'b1;
                end
            end
            default: phase_nx = PH_HWY_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HWY_GO;
        end else begin
            phase <= phase_nx;
        end
    end

    // R3
    hwy_min_green_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_GO && phase_nx != PH_HWY_GO) |-> long_done);

    // R5
    side_min_green_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIDE_GO && phase_nx != PH_SIDE_GO) |-> mid_done);

    // R4
    yellow_len_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_HWY_WARN || phase == PH_SIDE_WARN) && !short_done)
        |=> $stable(phase));

    // R2
    hwy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HWY_GO && !car && !ped_pending) |=> phase == PH_HWY_GO);

endmodule

// File: rtl/tlc_top.sv
module tlc_top
    import tlc_pkg::*;
#(
    parameter int LONG_TICKS  = 60,
    parameter int MID_TICKS   = 30,
    parameter int SHORT_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic side_car,
    input  logic ped_req,
    output logic hwy_red,
    output logic hwy_yel,
    output logic hwy_grn,
    output logic side_red,
    output logic side_yel,
    output logic side_grn
);
    localparam int NT = 3;
    localparam int PERIODS [NT] = '{LONG_TICKS, MID_TICKS, SHORT_TICKS};

    phase_t         phase;
    ctl_t           ctl;
    logic           ped_pending;
    logic [NT-1:0]  restart;
    logic [NT-1:0]  done;
    lamps_t         hwy_l;
    lamps_t         side_l;

    assign restart = {ctl.restart_short, ctl.restart_mid, ctl.restart_long};

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        tlc_interval_timer #(.PERIOD(PERIODS[i])) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .restart (restart[i]),
            .expired (done[i])
        );
    end

    tlc_ped_latch u_ped (
        .clk     (clk),
        .rst     (rst),
        .press   (ped_req),
        .serve   (ctl.ped_clear),
        .pending (ped_pending)
    );

    tlc_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .car         (side_car),
        .ped_pending (ped_pending),
        .long_done   (done[0]),
        .mid_done    (done[1]),
        .short_done  (done[2]),
        .phase       (phase),
        .ctl         (ctl)
    );

    assign hwy_l  = hwy_lamps(phase);
    assign side_l = side_lamps(phase);

    assign {hwy_red, hwy_yel, hwy_grn}    = hwy_l;
    assign {side_red, side_yel, side_grn} = side_l;

    // R9
    one_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({hwy_red, hwy_yel, hwy_grn}) && $onehot({side_red, side_yel, side_grn}));

    // R10
    no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        !((hwy_grn || hwy_yel) && (side_grn || side_yel)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (hwy_grn && side_red));

endmodule

// File: tb/sim_tlc_top.sv
module sim_tlc_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       car;
        logic       ped;
        logic [7:0] cyc;
        logic [5:0] exp;
    } vec_t;

    localparam logic [5:0] GR = 6'b001_100;
    localparam logic [5:0] YR = 6'b010_100;
    localparam logic [5:0] RG = 6'b100_001;
    localparam logic [5:0] RY = 6'b100_010;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd20, GR},  // R2 no demand, green held
        '{1'b1, 1'b0, 8'd1,  YR},  // R3 demand after minimum -> yellow
        '{1'b0, 1'b0, 8'd2,  YR},  // R4 yellow still on
        '{1'b0, 1'b0, 8'd1,  RG},  // R4 yellow ends -> side green
        '{1'b0, 1'b0, 8'd3,  RG},  // R5 sensor low, minimum still held
        '{1'b0, 1'b0, 8'd1,  RY},  // R5 minimum over -> side yellow
        '{1'b0, 1'b0, 8'd3,  GR},  // R4 side yellow ends -> highway green
        '{1'b1, 1'b0, 8'd6,  GR},  // R3 demand during minimum ignored
        '{1'b1, 1'b0, 8'd1,  YR},  // R3 minimum reached
        '{1'b1, 1'b0, 8'd3,  RG},  // R4 into side green
        '{1'b1, 1'b0, 8'd6,  RG},  // R6 sensor extends green
        '{1'b1, 1'b0, 8'd1,  RY},  // R6 ceiling reached
        '{1'b0, 1'b0, 8'd3,  GR},  // R4 back to highway
        '{1'b0, 1'b1, 8'd1,  GR},  // R7 pedestrian pulse in minimum
        '{1'b0, 1'b0, 8'd5,  GR},  // R7 minimum still running
        '{1'b0, 1'b0, 8'd1,  YR},  // R7 remembered request served
        '{1'b0, 1'b0, 8'd3,  RG},  // R7 side green
        '{1'b0, 1'b0, 8'd4,  RY},  // R5 no car -> minimum only
        '{1'b0, 1'b0, 8'd3,  GR},  // R4 highway again
        '{1'b0, 1'b0, 8'd30, GR}   // R7 request dropped, no second phase
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic side_car = 1'b0;
    logic ped_req = 1'b0;
    logic hwy_red, hwy_yel, hwy_grn, side_red, side_yel, side_grn;

    int n_chk = 0;
    int n_bad = 0;
    logic done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlc_top #(.LONG_TICKS(6), .MID_TICKS(3), .SHORT_TICKS(2)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .side_car(side_car), .ped_req(ped_req),
        .hwy_red(hwy_red), .hwy_yel(hwy_yel), .hwy_grn(hwy_grn),
        .side_red(side_red), .side_yel(side_yel), .side_grn(side_grn)
    );

    function automatic logic [5:0] lamps();
        return {hwy_red, hwy_yel, hwy_grn, side_red, side_yel, side_grn};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = lamps();
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s lamps got %b expected %b at %0t", req, got, exp, $time);
        end
        if (!$onehot(got[5:3]) || !$onehot(got[2:0])) begin
            n_bad++;
            $display("FAIL R9 lamp groups got %b expected one lit per road", got);
        end
        if ((got[4] || got[3]) && (got[1] || got[0])) begin
            n_bad++;
            $display("FAIL R10 lamps got %b expected no conflicting go", got);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        run(3);
        check("R1", GR);
        rst = 1'b0;
        run(1);
        check("R1", GR);
        rst = 1'b1;
        run(1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            side_car = VECS[i].car;
            ped_req  = VECS[i].ped;
            run(int'(VECS[i].cyc));
            ped_req = 1'b0;
            check($sformatf("R2-table vec %0d", i), VECS[i].exp);
        end

        // R8: timers frozen without ticks
        rst = 1'b1;
        run(1);
        rst = 1'b0;
        tick = 1'b0;
        side_car = 1'b1;
        run(40);
        check("R8 no ticks", GR);
        tick = 1'b1;
        run(6);
        check("R8 six ticks", GR);
        run(1);
        check("R3 after ticks", YR);
        // R8: tick on alternate cycles doubles yellow in clocks
        tick = 1'b0;
        run(1);
        tick = 1'b1;
        run(1);
        tick = 1'b0;
        run(1);
        check("R8 one tick in yellow", YR);
        tick = 1'b1;
        run(1);
        check("R8 second tick", YR);
        run(1);
        check("R4 after two ticks", RG);

        // R1: reset from side green
        rst = 1'b1;
        run(1);
        check("R1 mid-cycle", GR);
        rst = 1'b0;
        side_car = 1'b1;
        run(6);
        check("R1 timer restarted", GR);
        run(1);
        check("R3 after reset", YR);

        // R1: pending pedestrian dropped by reset
        side_car = 1'b0;
        rst = 1'b1;
        run(1);
        rst = 1'b0;
        ped_req = 1'b1;
        run(1);
        ped_req = 1'b0;
        rst = 1'b1;
        run(1);
        rst = 1'b0;
        run(20);
        check("R1 ped dropped", GR);

        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule